// File: doc/BRIEF.md
# Flow-Controlled Serial Port

This block is an asynchronous serial port with hardware handshaking in both directions. Its receiver recovers 8-bit frames from a serial line and places them in receive storage. That storage is either a one-byte holding register or an eight-entry first-in first-out buffer, selected by a control input. The request-to-send output `rts_out` follows how full the storage is. Low means the port can take another byte. High tells the remote transmitter to stop once its current frame is done. A host pops received bytes with a read strobe.

The transmitter sends bytes that the host writes in through a write strobe. When clear-to-send gating is enabled, a new frame may start only while `cts_in` is low. Each direction of flow control has its own enable.

Framing, noise and overrun conditions are kept in sticky flags. The flags change only at the end of a received byte. When enabled, any raised flag drives the interrupt output. The line timing comes from an oversampling strobe `os_tick` that the surrounding logic provides, at sixteen strobes per bit.

Top module: `uart_flow_port`

## Requirements
- R1: A received frame is one low start bit, eight data bits least significant bit first, and one high stop bit, each lasting 16 `os_tick` strobes. Each bit takes the majority of three samples at its centre. A start bit whose majority is high is dropped as a false start.
- R2: While `ctl_rts_en` is 0, `rts_out` stays 0, even when the receive storage is full.
- R3: With `ctl_rts_en`=1 and `ctl_fifo_mode`=0, `rts_out` goes to 1 once one byte is held. It returns to 0 in the cycle after the read strobe that empties the register.
- R4: With `ctl_rts_en`=1 and `ctl_fifo_mode`=1, the storage holds 8 bytes. `rts_out` is 1 only while all 8 are occupied. A read of a full buffer lowers `rts_out` in the following cycle.
- R5: A frame that completes while the storage is full is discarded. It sets `err_overrun`, which stays set until a pulse on `err_clear`.
- R6: A stop bit sampled low sets the sticky `err_frame`, and the byte is still stored.
- R7: If the three centre samples of any bit disagree, the sticky `err_noise` is set, and the majority value is stored.
- R8: `irq` equals `ctl_err_irq_en` AND-ed with the OR of the three error flags. The flags change only when a received byte has finished.
- R9: With `ctl_cts_en`=1, a new transmit frame starts only while `cts_in` is low. A frame already started always completes, even if `cts_in` rises during it.
- R10: With `ctl_cts_en`=0, a written byte is sent whatever the level of `cts_in`.
- R11: The transmitted frame uses the format of R1: low start bit, data least significant bit first, high stop bit, 16 strobes per bit. The line idles high. A write is accepted only while `tx_busy` is 0.
- R12: Received bytes come out in arrival order. `rd_data` shows the oldest held byte, and `rx_avail` is 1 while at least one byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| rx_line | input | 1 | Serial receive line |
| rts_out | output | 1 | Request-to-send, high asks the remote to pause |
| cts_in | input | 1 | Clear-to-send, low allows a new transmit frame |
| tx_line | output | 1 | Serial transmit line |
| ctl_rts_en | input | 1 | Enables request-to-send signalling |
| ctl_cts_en | input | 1 | Enables clear-to-send gating |
| ctl_fifo_mode | input | 1 | 1 selects the 8-entry buffer, 0 the single register |
| ctl_err_irq_en | input | 1 | Enables the error interrupt |
| rd_strobe | input | 1 | Pops the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| rx_avail | output | 1 | Receive storage not empty |
| rx_full | output | 1 | Receive storage at capacity |
| wr_strobe | input | 1 | Writes a byte for transmission |
| wr_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter holding or sending a byte |
| err_clear | input | 1 | Clears all error flags |
| err_frame | output | 1 | Sticky framing error |
| err_noise | output | 1 | Sticky noise error |
| err_overrun | output | 1 | Sticky overrun error |
| irq | output | 1 | Error interrupt |

## Verification
The bench uses the default parameters: 8 data bits, 16 strobes per bit and an 8-entry buffer. It ties `os_tick` high, so one bit lasts 16 clocks and one frame lasts 160 clocks. At this size the bench can fill the whole buffer with a handful of frames. That lets it test the exact full threshold of the request-to-send output and the read of a full buffer, as well as overruns in both storage modes. A one-clock glitch placed at a bit centre reaches exactly one of the three samples, so a noise flag can be provoked while the stored byte stays correct.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;

  // majority of three centre samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // the three samples do not all agree
  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_fc_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_bad_stop,
  output logic              frame_noisy
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] FIRST_SMP = CW'(OS_RATE/2 - 1);
  localparam logic [CW-1:0] LAST_CNT  = CW'(OS_RATE - 1);
  localparam logic [CW-1:0] STOP_EVAL = CW'(OS_RATE/2 + 2);

  logic rx_m, rx_s, rx_q;
  rx_state_e st;
  logic [CW-1:0] cnt;
  logic [2:0] smp;
  logic [BW-1:0] idx;
  logic [DATA_W-1:0] sh;
  logic noisy;

  wire fall_seen = rx_q & ~rx_s;
  wire in_window = (cnt >= FIRST_SMP) && (cnt <= FIRST_SMP + CW'(2));
  wire bit_end   = os_tick && (cnt == LAST_CNT);
  wire bit_val   = vote3(smp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_m, rx_s, rx_q} <= 3'b111;
      st <= RX_IDLE;
      cnt <= '0;
      smp <= '0;
      idx <= '0;
      sh <= '0;
      noisy <= 1'b0;
      frame_done <= 1'b0;
      frame_data <= '0;
      frame_bad_stop <= 1'b0;
      frame_noisy <= 1'b0;
    end else begin
      rx_m <= rx_line;
      rx_s <= rx_m;
      rx_q <= rx_s;
      frame_done <= 1'b0;
      if (st != RX_IDLE && os_tick) begin
        cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
        if (in_window) smp <= {smp[1:0], rx_s};
      end
      case (st)
        RX_IDLE: if (fall_seen) begin
          st <= RX_START;
          cnt <= '0;
          noisy <= 1'b0;
        end
        RX_START: if (bit_end) begin
          if (bit_val) st <= RX_IDLE;
          else begin
            st <= RX_DATA;
            idx <= '0;
            noisy <= split3(smp);
          end
        end
        RX_DATA: if (bit_end) begin
          sh <= {bit_val, sh[DATA_W-1:1]};
          noisy <= noisy | split3(smp);
          if (idx == BW'(DATA_W - 1)) st <= RX_STOP;
          else idx <= idx + 1'b1;
        end
        RX_STOP: if (os_tick && cnt == STOP_EVAL) begin
          st <= RX_IDLE;
          frame_done <= 1'b1;
          frame_data <= sh;
          frame_bad_stop <= ~bit_val;
          frame_noisy <= noisy | split3(smp);
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  function automatic logic [CNTW-1:0] capacity(input logic fm);
    return fm ? CNTW'(DEPTH) : CNTW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CNTW-1:0] cnt;

  assign full  = cnt >= capacity(fifo_mode);
  assign empty = (cnt == '0);
  assign head  = slot[rp];

  wire do_push = push & ~full;
  wire do_pop  = pop & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        slot[wp] <= push_data;
        wp <= ptr_next(wp);
      end
      if (do_pop) rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10: cnt <= cnt + 1'b1;
        2'b01: cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // occupancy never exceeds the physical depth
  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));

  // popping a full store frees room in the next cycle
  assert_pop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && full && !do_push |=> !full || (fifo_mode != $past(fifo_mode)));
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame import uart_fc_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cts_gate_en,
  input  logic              cts_in,
  output logic              tx_line,
  output logic              tx_busy
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(OS_RATE - 1);

  logic cts_m, cts_s;
  logic [DATA_W-1:0] hold;
  logic hold_v;
  tx_state_e st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DATA_W:0] sh;

  assign tx_line = sh[0];
  assign tx_busy = hold_v || (st != TX_IDLE);

  wire may_start = hold_v && (!cts_gate_en || !cts_s);
  wire bit_end   = os_tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cts_m, cts_s} <= 2'b11;
      hold <= '0;
      hold_v <= 1'b0;
      st <= TX_IDLE;
      cnt <= '0;
      idx <= '0;
      sh <= '1;
    end else begin
      cts_m <= cts_in;
      cts_s <= cts_m;
      if (wr_en && !tx_busy) begin
        hold <= wr_data;
        hold_v <= 1'b1;
      end
      if (st != TX_IDLE && os_tick) cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
      case (st)
        TX_IDLE: if (may_start) begin
          st <= TX_START;
          sh <= {hold, 1'b0};
          hold_v <= 1'b0;
          cnt <= '0;
        end
        TX_START: if (bit_end) begin
          sh <= {1'b1, sh[DATA_W:1]};
          idx <= '0;
          st <= TX_DATA;
        end
        TX_DATA: if (bit_end) begin
          sh <= {1'b1, sh[DATA_W:1]};
          if (idx == BW'(DATA_W - 1)) st <= TX_STOP;
          else idx <= idx + 1'b1;
        end
        TX_STOP: if (bit_end) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  // a high clear-to-send keeps an idle transmitter idle
  assert_cts_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cts_gate_en && cts_s && st == TX_IDLE |=> st == TX_IDLE);

  // a started frame runs to its stop bit whatever the handshake does
  assert_frame_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st != TX_IDLE && !(st == TX_STOP && bit_end) |=> st != TX_IDLE);

  // the line rests high between frames
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st == TX_IDLE |-> tx_line);
endmodule

// File: rtl/uart_flow_port.sv
module uart_flow_port import uart_fc_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int OS_RATE  = 16,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  output logic              rts_out,
  input  logic              cts_in,
  output logic              tx_line,
  input  logic              ctl_rts_en,
  input  logic              ctl_cts_en,
  input  logic              ctl_fifo_mode,
  input  logic              ctl_err_irq_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_avail,
  output logic              rx_full,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_busy,
  input  logic              err_clear,
  output logic              err_frame,
  output logic              err_noise,
  output logic              err_overrun,
  output logic              irq
);
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_bad_stop;
  logic              frame_noisy;
  logic              rx_empty;

  uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_bad_stop(frame_bad_stop), .frame_noisy(frame_noisy)
  );

  uart_rx_store #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_mode(ctl_fifo_mode),
    .push(frame_done), .push_data(frame_data), .pop(rd_strobe),
    .head(rd_data), .full(rx_full), .empty(rx_empty)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .wr_en(wr_strobe), .wr_data(wr_data),
    .cts_gate_en(ctl_cts_en), .cts_in(cts_in),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  wire overrun_evt = frame_done & rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_frame <= 1'b0;
      err_noise <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      err_frame   <= (err_frame & ~err_clear) | (frame_done & frame_bad_stop);
      err_noise   <= (err_noise & ~err_clear) | (frame_done & frame_noisy);
      err_overrun <= (err_overrun & ~err_clear) | overrun_evt;
    end
  end

  assign rx_avail = ~rx_empty;
  assign rts_out  = ctl_rts_en & rx_full;
  assign irq      = ctl_err_irq_en & (err_frame | err_noise | err_overrun);

  // overrun is only ever recorded for a byte that arrived into full storage
  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(frame_done) && $past(rx_full));

  // with the enable steady, the interrupt rises only after a byte has ended
  assert_irq_at_byte_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && $past(ctl_err_irq_en) |-> $past(frame_done));
endmodule

// File: tb/test_uart_flow_port.sv
module test_uart_flow_port;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1, cts_in = 1'b1;
  logic ctl_rts_en = 1'b0, ctl_cts_en = 1'b0, ctl_fifo_mode = 1'b0, ctl_err_irq_en = 1'b0;
  logic rd_strobe = 1'b0, wr_strobe = 1'b0, err_clear = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rts_out, tx_line, rx_avail, rx_full, tx_busy, err_frame, err_noise, err_overrun, irq;
  logic [7:0] rd_data;

  int n_checks = 0, n_fail = 0, tx_frames = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  logic [7:0] rd_seen;
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_port i_uart_flow_port (
    .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rx_line(rx_line), .rts_out(rts_out),
    .cts_in(cts_in), .tx_line(tx_line), .ctl_rts_en(ctl_rts_en), .ctl_cts_en(ctl_cts_en),
    .ctl_fifo_mode(ctl_fifo_mode), .ctl_err_irq_en(ctl_err_irq_en), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rx_avail(rx_avail), .rx_full(rx_full), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .tx_busy(tx_busy), .err_clear(err_clear), .err_frame(err_frame),
    .err_noise(err_noise), .err_overrun(err_overrun), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drives one frame onto rx_line; expected bytes go to the scoreboard queue
  task automatic send_rx(input logic [7:0] b, input bit stop_v, input bit glitch, input bit expect_it);
    if (expect_it) rx_q.push_back(b);
    @(negedge clk) rx_line = 1'b0;
    repeat (BITC-1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rx_line = b[i];
      if (glitch && i == 3) begin
        repeat (8) @(negedge clk);
        rx_line = ~b[i];
        @(negedge clk) rx_line = b[i];
        repeat (BITC-10) @(negedge clk);
      end else begin
        if (glitch && i == 5) check(err_noise == 1'b0, "R8 flag before byte end", err_noise, 0);
        repeat (BITC-1) @(negedge clk);
      end
    end
    @(negedge clk) rx_line = stop_v;
    repeat (BITC-1) @(negedge clk);
    @(negedge clk) rx_line = 1'b1;
    repeat (BITC-1) @(negedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk);
    rd_seen = rd_data;
    rd_strobe = 1'b1;
    -> rd_ev;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_q.push_back(b);
    @(negedge clk) begin wr_data = b; wr_strobe = 1'b1; end
    @(negedge clk) wr_strobe = 1'b0;
  endtask

  task automatic wait_tx_done();
    int guard = 0;
    while (tx_busy && guard < 1000) begin @(negedge clk); guard++; end
    repeat (20) @(negedge clk);
  endtask

  // receive monitor: compares each popped byte with the scoreboard
  initial begin : rx_mon
    forever begin
      @(rd_ev);
      if (rx_q.size() == 0) check(1'b0, "R12 unexpected read", rd_seen, 0);
      else begin
        logic [7:0] e;
        e = rx_q.pop_front();
        check(rd_seen == e, "R1/R12 received byte", rd_seen, e);
      end
    end
  end

  // transmit monitor: decodes frames at bit centres
  initial begin : tx_mon
    logic prev;
    logic [7:0] got;
    logic stop_b;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx_line) begin
        repeat (8) @(negedge clk);
        check(tx_line == 1'b0, "R11 start bit", tx_line, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = tx_line;
        end
        repeat (BITC) @(negedge clk);
        stop_b = tx_line;
        check(stop_b == 1'b1, "R11 stop bit", stop_b, 1);
        if (tx_q.size() == 0) check(1'b0, "R11 unexpected frame", got, 0);
        else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          check(got == e, "R11 transmitted byte", got, e);
        end
        tx_frames++;
      end
      prev = tx_line;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int lows;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rts_out == 0 && tx_line == 1 && irq == 0 && rx_avail == 0 && tx_busy == 0,
          "reset R11", {rts_out, tx_line, irq, rx_avail, tx_busy}, 5'b01000);
    check({err_frame, err_noise, err_overrun} == 3'b000, "reset R8 flags",
          {err_frame, err_noise, err_overrun}, 0);

    // R1, R3: single register with request-to-send
    ctl_rts_en = 1'b1;
    send_rx(8'hA5, 1'b1, 1'b0, 1'b1);
    check(rts_out == 1'b1, "R3 rts high when held", rts_out, 1);
    check(rx_avail == 1'b1, "R12 avail", rx_avail, 1);
    read_rx();
    check(rts_out == 1'b0, "R3 rts low after read", rts_out, 0);

    // R5, R8: overrun in single mode
    send_rx(8'h3C, 1'b1, 1'b0, 1'b1);
    send_rx(8'h99, 1'b1, 1'b0, 1'b0);
    check(err_overrun == 1'b1, "R5 overrun set", err_overrun, 1);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    read_rx();
    check(rx_avail == 1'b0, "R5 discarded byte not stored", rx_avail, 0);
    check(err_overrun == 1'b1, "R5 overrun sticky", err_overrun, 1);
    ctl_err_irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R8 irq enabled", irq, 1);
    pulse_clear();
    check(err_overrun == 0 && irq == 0, "R5 clear", {err_overrun, irq}, 0);

    // R6: framing error still stores the byte
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    check(err_frame == 1'b1, "R6 framing flag", err_frame, 1);
    check(irq == 1'b1, "R8 irq on framing", irq, 1);
    read_rx();
    pulse_clear();

    // R7: single-sample glitch
    send_rx(8'h0F, 1'b1, 1'b1, 1'b1);
    check(err_noise == 1'b1, "R7 noise flag", err_noise, 1);
    check(err_frame == 1'b0, "R7 no framing", err_frame, 0);
    read_rx();
    pulse_clear();
    ctl_err_irq_en = 1'b0;

    // R2: request-to-send disabled
    ctl_rts_en = 1'b0;
    send_rx(8'h81, 1'b1, 1'b0, 1'b1);
    check(rx_full == 1'b1 && rts_out == 1'b0, "R2 rts held low", rts_out, 0);
    read_rx();

    // R4, R12: eight-entry buffer
    ctl_rts_en = 1'b1;
    ctl_fifo_mode = 1'b1;
    for (int k = 0; k < 7; k++) send_rx(8'h10 + 8'(k * 17), 1'b1, 1'b0, 1'b1);
    check(rts_out == 1'b0, "R4 rts low at 7", rts_out, 0);
    check(rx_avail == 1'b1, "R12 avail with data", rx_avail, 1);
    send_rx(8'hEE, 1'b1, 1'b0, 1'b1);
    check(rts_out == 1'b1, "R4 rts high at 8", rts_out, 1);
    read_rx();
    check(rts_out == 1'b0, "R4 rts low after read of full", rts_out, 0);
    for (int k = 0; k < 7; k++) read_rx();
    check(rx_avail == 1'b0, "R12 drained", rx_avail, 0);
    check(rx_q.size() == 0, "R12 scoreboard empty", rx_q.size(), 0);
    ctl_fifo_mode = 1'b0;

    // R10: gating off, clear-to-send ignored
    ctl_cts_en = 1'b0;
    cts_in = 1'b1;
    base = tx_frames;
    write_tx(8'hC3);
    wait_tx_done();
    check(tx_frames == base + 1, "R10 sent despite cts high", tx_frames, base + 1);

    // R9: gating on
    ctl_cts_en = 1'b1;
    base = tx_frames;
    write_tx(8'h96);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!tx_line) lows++; end
    check(lows == 0 && tx_frames == base, "R9 blocked while cts high", lows, 0);
    check(tx_busy == 1'b1, "R9 byte pending", tx_busy, 1);
    cts_in = 1'b0;
    repeat (40) @(negedge clk);
    cts_in = 1'b1;
    wait_tx_done();
    check(tx_frames == base + 1, "R9 frame completes after cts rise", tx_frames, base + 1);
    check(tx_q.size() == 0, "R11 scoreboard empty", tx_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule